// File: doc/BRIEF.md
# Wake-up Clock Exit-Delay Sequencer

This block times the wait a processor core must observe between a wake event and the resumption of instruction execution, after the core has been in sleep or in primary-idle. At the moment a wake is accepted, the block looks at three things: the power-managed mode the core is leaving, the clock source code selected for operation after wake-up, and the non-zero interval parameters. From these it builds a chain of up to four timed phases. The phases are crystal start-up, PLL lock, internal-oscillator stabilization and a fixed core-prepare interval. Each phase is counted in ticks of a reference clock. The block then emits a one-cycle release strobe.

Two status flags report which clock family became ready. The primary flag covers crystal, PLL, external-clock and RC sources. The internal flag covers the fast internal oscillator and its divided frequencies. A busy output marks the span of a running sequence. A sleep or idle entry indication clears both flags.

Top module: `wake_exit_seq`

## Requirements
- R1: Source code 0 (crystal family) woken from sleep (`idle_mode`=0) releases after OST_TICKS + PREP_TICKS counted ticks and sets only `pri_rdy`.
- R2: Source code 1 (crystal with PLL) woken from sleep releases after OST_TICKS + PLL_TICKS + PREP_TICKS counted ticks and sets only `pri_rdy`.
- R3: With `idle_mode`=1 (primary clock kept running), source codes 0 and 1 skip both the start-up and the PLL waits and release after PREP_TICKS ticks, setting only `pri_rdy`.
- R4: Source codes 2 (external clock), 3 (RC), 6 and 7 need no start-up wait in either mode: release after PREP_TICKS ticks, only `pri_rdy` set.
- R5: Source code 4 (fast internal oscillator or a divided frequency of it) releases after STAB_TICKS + PREP_TICKS ticks in either mode and sets only `int_rdy`.
- R6: Source code 5 (slow internal RC) releases after PREP_TICKS ticks and leaves both flags low.
- R7: Ticks are counted only on clock edges where `tick` is high, starting after the edge that accepts the wake. `cpu_go` is high for exactly one cycle, beginning at the edge that samples the last required tick. When the total is zero, it begins at the accepting edge itself.
- R8: `busy` is high in every cycle from the accepting edge until the release edge when the total wait is non-zero. It is low in the `cpu_go` cycle and while no sequence runs.
- R9: A `wake` that arrives while a sequence is running is ignored; the running sequence keeps its source, timing and flags.
- R10: An interval parameter of zero removes its phase with no added cycle; with every interval zero, each accepted wake is released at the accepting edge.
- R11: `pm_enter` clears both flags at the next edge. At most one flag is high at any time. Flags change only when a sequence's start-up waits end or on `pm_enter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Reference-clock tick enable used for all interval counting |
| pm_enter | input | 1 | Sleep or idle entry indication; clears the ready flags |
| wake | input | 1 | Wake event; accepted only when no sequence runs |
| idle_mode | input | 1 | Mode being left: 0 sleep, 1 primary-idle |
| src_sel | input | 3 | Post-wake clock source code (0 crystal, 1 crystal+PLL, 2 external, 3 RC, 4 fast internal, 5 slow internal, 6/7 external) |
| cpu_go | output | 1 | One-cycle release strobe for instruction execution |
| busy | output | 1 | High while a wake sequence is waiting |
| pri_rdy | output | 1 | Primary oscillator family ready |
| int_rdy | output | 1 | Fast internal oscillator ready |

## Verification
The assertions check on every cycle the properties that do not depend on the source. The release strobe lasts one cycle, busy and release never overlap, and busy ends only with a release. A wake is never accepted while busy. The flags are one-hot-or-zero, are cleared after an entry indication, and move only at the end of the start-up waits. What each source code and mode costs in counted ticks, which flag it raises, and whether a mid-sequence wake leaves the timing intact can only be shown by the bench's scenarios. Those scenarios use sparse and dense tick patterns and run against a second instance with every interval set to zero.

// File: rtl/wkx_pkg.sv
package wkx_pkg;

  localparam logic [2:0] SRC_XTAL     = 3'd0;
  localparam logic [2:0] SRC_XTAL_PLL = 3'd1;
  localparam logic [2:0] SRC_EXTCLK   = 3'd2;
  localparam logic [2:0] SRC_RC       = 3'd3;
  localparam logic [2:0] SRC_INT_FAST = 3'd4;
  localparam logic [2:0] SRC_INT_SLOW = 3'd5;

  // Phase encoding order is the order in which phases are run.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OST  = 3'd1,
    PH_PLL  = 3'd2,
    PH_STAB = 3'd3,
    PH_PREP = 3'd4,
    PH_REL  = 3'd5
  } phase_t;

  typedef struct packed {
    logic ost;
    logic pll;
    logic stab;
    logic prep;
    logic fam_pri;
    logic fam_int;
  } path_t;

  // Which phases a wake needs, and which ready flag it raises.
  function automatic path_t decode_path(input logic [2:0] src, input logic idle,
                                        input logic ost_nz, input logic pll_nz,
                                        input logic stab_nz, input logic prep_nz);
    path_t p;
    logic  is_xtal, is_pll;
    is_xtal   = (src == SRC_XTAL) || (src == SRC_XTAL_PLL);
    is_pll    = (src == SRC_XTAL_PLL);
    p.ost     = is_xtal && !idle && ost_nz;
    p.pll     = is_pll && !idle && pll_nz;
    p.stab    = (src == SRC_INT_FAST) && stab_nz;
    p.prep    = prep_nz;
    p.fam_int = (src == SRC_INT_FAST);
    p.fam_pri = (src != SRC_INT_FAST) && (src != SRC_INT_SLOW);
    return p;
  endfunction

  // First enabled phase strictly after cur; release when none remains.
  function automatic phase_t next_phase(input phase_t cur, input path_t p);
    phase_t r;
    r = PH_REL;
    if (cur < PH_PREP && p.prep) r = PH_PREP;
    if (cur < PH_STAB && p.stab) r = PH_STAB;
    if (cur < PH_PLL  && p.pll)  r = PH_PLL;
    if (cur < PH_OST  && p.ost)  r = PH_OST;
    return r;
  endfunction

  function automatic logic is_wait_phase(input phase_t ph);
    return (ph == PH_OST) || (ph == PH_PLL) || (ph == PH_STAB) || (ph == PH_PREP);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned width_for(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/wkx_path_sel.sv
module wkx_path_sel
  import wkx_pkg::*;
#(
  parameter int unsigned OST_TICKS  = 1024,
  parameter int unsigned PLL_TICKS  = 2048,
  parameter int unsigned STAB_TICKS = 64,
  parameter int unsigned PREP_TICKS = 10
) (
  input  logic [2:0] src_sel,
  input  logic       idle_mode,
  output path_t      path
);
  localparam logic OST_NZ  = (OST_TICKS  != 0);
  localparam logic PLL_NZ  = (PLL_TICKS  != 0);
  localparam logic STAB_NZ = (STAB_TICKS != 0);
  localparam logic PREP_NZ = (PREP_TICKS != 0);

  always_comb begin
    path = decode_path(src_sel, idle_mode, OST_NZ, PLL_NZ, STAB_NZ, PREP_NZ);
  end
endmodule

// File: rtl/wkx_tick_cnt.sv
module wkx_tick_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          active,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (active && tick) cnt_q <= cnt_q + CW'(1);
  end

  assign done = active && tick && (cnt_q == (limit - CW'(1)));
endmodule

// File: rtl/wkx_phase_fsm.sv
module wkx_phase_fsm
  import wkx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wake,
  input  logic   pm_enter,
  input  logic   done,
  input  path_t  path_live,
  output phase_t phase_q,
  output logic   accept,
  output logic   wait_end,
  output logic   phase_chg,
  output logic   cpu_go,
  output logic   busy,
  output logic   pri_rdy,
  output logic   int_rdy
);
  phase_t ph_d;
  path_t  path_q, path_use;

  assign path_use = (phase_q == PH_IDLE) ? path_live : path_q;

  always_comb begin
    ph_d   = phase_q;
    accept = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (wake) begin
        accept = 1'b1;
        ph_d   = next_phase(PH_IDLE, path_live);
      end
      PH_OST, PH_PLL, PH_STAB, PH_PREP: if (done) ph_d = next_phase(phase_q, path_q);
      PH_REL:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign phase_chg = (ph_d != phase_q);
  assign wait_end  = phase_chg && ((ph_d == PH_PREP) || (ph_d == PH_REL)) &&
                     ((phase_q == PH_IDLE) || (phase_q == PH_OST) ||
                      (phase_q == PH_PLL)  || (phase_q == PH_STAB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      path_q  <= '0;
    end else begin
      phase_q <= ph_d;
      if (accept) path_q <= path_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_rdy <= 1'b0;
      int_rdy <= 1'b0;
    end else if (pm_enter) begin
      pri_rdy <= 1'b0;
      int_rdy <= 1'b0;
    end else if (wait_end) begin
      pri_rdy <= path_use.fam_pri;
      int_rdy <= path_use.fam_int;
    end
  end

  assign cpu_go = (phase_q == PH_REL);
  assign busy   = is_wait_phase(phase_q);
endmodule

// File: rtl/wake_exit_seq.sv
module wake_exit_seq
  import wkx_pkg::*;
#(
  parameter int unsigned OST_TICKS  = 1024,
  parameter int unsigned PLL_TICKS  = 2048,
  parameter int unsigned STAB_TICKS = 64,
  parameter int unsigned PREP_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pm_enter,
  input  logic       wake,
  input  logic       idle_mode,
  input  logic [2:0] src_sel,
  output logic       cpu_go,
  output logic       busy,
  output logic       pri_rdy,
  output logic       int_rdy
);
  localparam int unsigned MAXLEN = max4(OST_TICKS, PLL_TICKS, STAB_TICKS, PREP_TICKS);
  localparam int unsigned CW     = width_for(MAXLEN);

  path_t         path_live;
  phase_t        phase_w;
  logic          accept_w, wait_end_w, phase_chg_w, done_w;
  logic [CW-1:0] limit_w;

  wkx_path_sel #(
    .OST_TICKS (OST_TICKS),
    .PLL_TICKS (PLL_TICKS),
    .STAB_TICKS(STAB_TICKS),
    .PREP_TICKS(PREP_TICKS)
  ) u_path (
    .src_sel  (src_sel),
    .idle_mode(idle_mode),
    .path     (path_live)
  );

  always_comb begin
    unique case (phase_w)
      PH_OST:  limit_w = CW'(OST_TICKS);
      PH_PLL:  limit_w = CW'(PLL_TICKS);
      PH_STAB: limit_w = CW'(STAB_TICKS);
      PH_PREP: limit_w = CW'(PREP_TICKS);
      default: limit_w = '0;
    endcase
  end

  wkx_tick_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phase_chg_w),
    .active(busy),
    .tick  (tick),
    .limit (limit_w),
    .done  (done_w)
  );

  wkx_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake     (wake),
    .pm_enter (pm_enter),
    .done     (done_w),
    .path_live(path_live),
    .phase_q  (phase_w),
    .accept   (accept_w),
    .wait_end (wait_end_w),
    .phase_chg(phase_chg_w),
    .cpu_go   (cpu_go),
    .busy     (busy),
    .pri_rdy  (pri_rdy),
    .int_rdy  (int_rdy)
  );
endmodule

// File: rtl/wkx_chk.sv
module wkx_chk (
  input logic clk,
  input logic rst_n,
  input logic pm_enter,
  input logic cpu_go,
  input logic busy,
  input logic pri_rdy,
  input logic int_rdy,
  input logic accept,
  input logic wait_end
);
  assert_go_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |=> !cpu_go);

  assert_go_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |-> ($past(busy) || $past(accept)));

  assert_busy_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && cpu_go));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cpu_go);

  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pm_enter |=> (!pri_rdy && !int_rdy));

  assert_flag_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pri_rdy, int_rdy}));

  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_enter && !wait_end) |=> $stable({pri_rdy, int_rdy}));
endmodule

bind wake_exit_seq wkx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pm_enter(pm_enter),
  .cpu_go  (cpu_go),
  .busy    (busy),
  .pri_rdy (pri_rdy),
  .int_rdy (int_rdy),
  .accept  (accept_w),
  .wait_end(wait_end_w)
);

// File: tb/sim_wake_exit_seq.sv
`timescale 1ns/1ps
module sim_wake_exit_seq;
  localparam int OST = 5, PLL = 3, STB = 4, PRP = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tick, pm_enter, wake, idle_mode;
  logic [2:0] src_sel;
  logic go0, busy0, pri0, int0;
  logic go1, busy1, pri1, int1;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  wake_exit_seq #(.OST_TICKS(OST), .PLL_TICKS(PLL), .STAB_TICKS(STB), .PREP_TICKS(PRP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pm_enter(pm_enter), .wake(wake),
    .idle_mode(idle_mode), .src_sel(src_sel),
    .cpu_go(go0), .busy(busy0), .pri_rdy(pri0), .int_rdy(int0));

  wake_exit_seq #(.OST_TICKS(0), .PLL_TICKS(0), .STAB_TICKS(0), .PREP_TICKS(0)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pm_enter(pm_enter), .wake(wake),
    .idle_mode(idle_mode), .src_sel(src_sel),
    .cpu_go(go1), .busy(busy1), .pri_rdy(pri1), .int_rdy(int1));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int src, input bit idl);
    int t;
    t = PRP;
    if (src == 0 && !idl) t += OST;
    if (src == 1 && !idl) t += OST + PLL;
    if (src == 4) t += STB;
    return t;
  endfunction

  function automatic bit exp_pri(input int src);
    return !(src == 4 || src == 5);
  endfunction

  function automatic bit exp_int(input int src);
    return src == 4;
  endfunction

  function automatic string tag_of(input int src, input bit idl);
    if ((src == 0 || src == 1) && idl) return "R3";
    if (src == 0) return "R1";
    if (src == 1) return "R2";
    if (src == 4) return "R5";
    if (src == 5) return "R6";
    return "R4";
  endfunction

  function automatic bit pick_tick(input bit dense);
    return dense ? 1'b1 : ($urandom % 3 == 0);
  endfunction

  task automatic run_wake(input int src, input bit idl, input bit inj, input bit dense);
    int ticks = 0, cyc = 0;
    bit busy_ok = 1;
    string tg;
    tg = tag_of(src, idl);
    @(negedge clk);
    wake = 1'b1; src_sel = 3'(src); idle_mode = idl; tick = pick_tick(dense);
    @(posedge clk); #1;
    chk(go1 == 1'b1, "R10", "zero-interval release at accept edge", go1, 1);
    chk(pri1 == exp_pri(src) && int1 == exp_int(src), "R10", "zero-interval flags",
        {pri1, int1}, {exp_pri(src), exp_int(src)});
    while (!go0 && cyc < 500) begin
      if (!busy0) busy_ok = 0;
      @(negedge clk);
      wake = inj && (cyc == 1);
      if (wake) begin src_sel = 3'($urandom % 8); idle_mode = $urandom % 2; end
      tick = pick_tick(dense);
      @(posedge clk);
      if (tick) ticks++;
      #1;
      cyc++;
    end
    chk(go0 == 1'b1, "R7", "release strobe seen", go0, 1);
    chk(ticks == exp_ticks(src, idl), tg, "ticks before release", ticks, exp_ticks(src, idl));
    if (inj)
      chk(ticks == exp_ticks(src, idl), "R9", "mid-sequence wake ignored", ticks, exp_ticks(src, idl));
    chk(busy_ok, "R8", "busy held while waiting", busy_ok, 1);
    chk(busy0 == 1'b0, "R8", "busy low in release cycle", busy0, 0);
    chk(pri0 == exp_pri(src), tg, "pri_rdy at release", pri0, exp_pri(src));
    chk(int0 == exp_int(src), tg, "int_rdy at release", int0, exp_int(src));
    @(negedge clk);
    wake = 1'b0; tick = 1'b0;
    @(posedge clk); #1;
    chk(go0 == 1'b0, "R7", "release strobe one cycle", go0, 0);
  endtask

  task automatic pulse_pm();
    @(negedge clk); pm_enter = 1'b1;
    @(posedge clk); #1;
    chk(!pri0 && !int0, "R11", "flags cleared by entry", {pri0, int0}, 0);
    @(negedge clk); pm_enter = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tick = 1'b0; pm_enter = 1'b0; wake = 1'b0; idle_mode = 1'b0; src_sel = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!go0 && !busy0, "R8", "reset idle outputs", {go0, busy0}, 0);
    chk(!pri0 && !int0, "R11", "reset flags low", {pri0, int0}, 0);

    run_wake(0, 0, 0, 1);
    run_wake(1, 0, 0, 1);
    run_wake(0, 1, 0, 1);
    run_wake(1, 1, 0, 0);
    run_wake(2, 0, 0, 1);
    run_wake(3, 1, 0, 0);
    run_wake(4, 0, 0, 1);
    run_wake(4, 1, 1, 0);
    run_wake(5, 0, 0, 1);
    run_wake(7, 1, 0, 1);
    run_wake(1, 0, 1, 0);
    pulse_pm();
    run_wake(4, 0, 0, 1);
    pulse_pm();

    for (int i = 0; i < 60; i++) begin
      if ($urandom % 5 == 0) pulse_pm();
      run_wake($urandom % 8, $urandom % 2, ($urandom % 3) == 0, $urandom % 2);
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule